// File: doc/BRIEF.md
# Pedestrian Crossing Signal Controller

This block sequences the lamps at a single pedestrian crossing. Vehicles hold a green light until a pedestrian press on the request button is sampled. The vehicle lamp then passes through one cycle of amber and turns red while the pedestrians get a green lamp. The walk interval is a short countdown that decrements once per clock. The remaining count is shown on one seven-segment digit. When the walk ends, the crossing returns to vehicle green.

Presses that arrive during the amber or walk phases are dropped, not stored, so one request always gives exactly one crossing cycle of fixed length. While no countdown runs, the digit shows a fixed idle symbol chosen by a parameter. Reset is asynchronous and active high. The block has no data stream, so every pin is a plain level signal with no handshake.

Top module: `pedx_signal_ctrl`

## Requirements
- R1: While `rst` is high, and immediately on its assertion without waiting for a clock, the outputs show vehicle green and pedestrian red, `walk_cnt` is 0 and the digit shows `IDLE_DIGIT`.
- R2: In the idle phase with `walk_req` low at a rising edge, vehicle green and pedestrian red stay on after that edge.
- R3: In the idle phase with `walk_req` high at a rising edge, the next state shows vehicle amber and pedestrian red, with vehicle green off.
- R4: One edge after the amber state, vehicle red and pedestrian green are on, amber and pedestrian red are off, and `walk_cnt` equals `WALK_START`.
- R5: During the walk phase, `walk_cnt` falls by one on each edge, and each value from `WALK_START` down to 0 is held for one cycle. On the edge after the count 0 cycle, the block returns to vehicle green and pedestrian red.
- R6: A `walk_req` seen during amber or walk is discarded. If the button is low once idle is reached, the block stays in vehicle green, and the walk lasts exactly `WALK_START`+1 cycles whatever presses occur.
- R7: Exactly one vehicle lamp is on at all times. Pedestrian green is on exactly when vehicle red is on, and pedestrian red is on otherwise.
- R8: `seg_abcdefg` is active high with bit 6 = a down to bit 0 = g. It shows `walk_cnt` during the walk phase and `IDLE_DIGIT` otherwise. The patterns are 0=7E, 1=30, 2=6D, 3=79, 4=33, 5=5B, 6=5F, 7=70, 8=7F and 9=7B (hex).
- R9: `walk_cnt` is 0 whenever the walk phase is not active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high reset |
| walk_req | input | 1 | Pedestrian request button, sampled on the rising edge |
| veh_grn | output | 1 | Vehicle green lamp |
| veh_amb | output | 1 | Vehicle amber lamp |
| veh_red | output | 1 | Vehicle red lamp |
| ped_grn | output | 1 | Pedestrian green lamp |
| ped_red | output | 1 | Pedestrian red lamp |
| walk_cnt | output | CNT_W | Remaining walk count, 0 outside the walk phase |
| seg_abcdefg | output | 7 | Seven-segment pattern, a in bit 6, g in bit 0, active high |

## Verification
The bench builds the block with the default `WALK_START` of 2 and sets `IDLE_DIGIT` to 7. Because 7 never appears as a countdown value, any slip between the idle digit and the count on the display is visible on the segments. The 2-to-0 countdown reaches the count 0 exit edge within three cycles, so the bench can exercise many back-to-back requests, held presses and presses during amber and walk. An asynchronous reset in the middle of a walk is also applied and checked before the next clock edge.

// File: rtl/pedx_pkg.sv
package pedx_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_AMBER = 2'd1,
    PH_WALK  = 2'd2
  } phase_t;

  // Segment order {a,b,c,d,e,f,g}, active high
  function automatic logic [6:0] seg_of(input logic [3:0] digit);
    logic [6:0] pat;
    case (digit)
      4'd0:    pat = 7'h7E;
      4'd1:    pat = 7'h30;
      4'd2:    pat = 7'h6D;
      4'd3:    pat = 7'h79;
      4'd4:    pat = 7'h33;
      4'd5:    pat = 7'h5B;
      4'd6:    pat = 7'h5F;
      4'd7:    pat = 7'h70;
      4'd8:    pat = 7'h7F;
      4'd9:    pat = 7'h7B;
      default: pat = 7'h00;
    endcase
    return pat;
  endfunction

endpackage

// File: rtl/pedx_phase_seq.sv
module pedx_phase_seq
  import pedx_pkg::*;
#(
  parameter int WALK_START = 2,
  parameter int CNT_W      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             walk_req,
  output phase_t           phase,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WALK_START);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          cnt <= '0;
          if (walk_req) phase <= PH_AMBER;
        end
        PH_AMBER: begin
          phase <= PH_WALK;
          cnt   <= LOAD_VAL;
        end
        PH_WALK: begin
          if (cnt == '0) phase <= PH_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/pedx_lamp_dec.sv
module pedx_lamp_dec
  import pedx_pkg::*;
(
  input  phase_t phase,
  output logic   veh_grn,
  output logic   veh_amb,
  output logic   veh_red,
  output logic   ped_grn,
  output logic   ped_red
);

  always_comb begin
    veh_grn = 1'b0;
    veh_amb = 1'b0;
    veh_red = 1'b0;
    ped_grn = 1'b0;
    ped_red = 1'b1;
    case (phase)
      PH_AMBER: veh_amb = 1'b1;
      PH_WALK: begin
        veh_red = 1'b1;
        ped_grn = 1'b1;
        ped_red = 1'b0;
      end
      default:  veh_grn = 1'b1;
    endcase
  end

endmodule

// File: rtl/pedx_seg_drv.sv
module pedx_seg_drv
  import pedx_pkg::*;
#(
  parameter int IDLE_DIGIT = 0,
  parameter int CNT_W      = 2
) (
  input  phase_t           phase,
  input  logic [CNT_W-1:0] cnt,
  output logic [6:0]       seg
);

  localparam logic [6:0] IDLE_SEG = seg_of(4'(IDLE_DIGIT));

  logic [3:0] digit;

  always_comb begin
    digit = 4'(cnt);
    seg   = (phase == PH_WALK) ? seg_of(digit) : IDLE_SEG;
  end

endmodule

// File: rtl/pedx_signal_ctrl.sv
module pedx_signal_ctrl
  import pedx_pkg::*;
#(
  parameter int WALK_START = 2,
  parameter int IDLE_DIGIT = 0,
  parameter int CNT_W      = $clog2(WALK_START + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             walk_req,
  output logic             veh_grn,
  output logic             veh_amb,
  output logic             veh_red,
  output logic             ped_grn,
  output logic             ped_red,
  output logic [CNT_W-1:0] walk_cnt,
  output logic [6:0]       seg_abcdefg
);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;

  pedx_phase_seq #(.WALK_START(WALK_START), .CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .walk_req (walk_req),
    .phase    (phase),
    .cnt      (cnt)
  );

  pedx_lamp_dec u_lamp (
    .phase   (phase),
    .veh_grn (veh_grn),
    .veh_amb (veh_amb),
    .veh_red (veh_red),
    .ped_grn (ped_grn),
    .ped_red (ped_red)
  );

  pedx_seg_drv #(.IDLE_DIGIT(IDLE_DIGIT), .CNT_W(CNT_W)) u_seg (
    .phase (phase),
    .cnt   (cnt),
    .seg   (seg_abcdefg)
  );

  assign walk_cnt = cnt;

endmodule

// File: rtl/pedx_signal_ctrl_chk.sv
module pedx_signal_ctrl_chk #(
  parameter int WALK_START = 2,
  parameter int CNT_W      = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             walk_req,
  input logic             veh_grn,
  input logic             veh_amb,
  input logic             veh_red,
  input logic             ped_grn,
  input logic             ped_red,
  input logic [CNT_W-1:0] walk_cnt
);

  // R2
  hold_green_chk: assert property (@(posedge clk) disable iff (rst)
    (veh_grn && !walk_req) |=> (veh_grn && ped_red));

  // R3
  go_amber_chk: assert property (@(posedge clk) disable iff (rst)
    (veh_grn && walk_req) |=> (veh_amb && ped_red && !veh_grn));

  // R4
  amber_to_walk_chk: assert property (@(posedge clk) disable iff (rst)
    veh_amb |=> (veh_red && ped_grn && walk_cnt == CNT_W'(WALK_START)));

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (veh_red && walk_cnt != '0) |=>
      (veh_red && walk_cnt == CNT_W'($past(walk_cnt) - 1'b1)));

  // R5
  walk_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (veh_red && walk_cnt == '0) |=> (veh_grn && ped_red));

  // R7
  one_vehicle_lamp_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({veh_grn, veh_amb, veh_red}) == 1);

  // R7
  ped_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (ped_grn == veh_red) && (ped_red != ped_grn));

  // R9
  idle_count_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !veh_red |-> (walk_cnt == '0));

endmodule

bind pedx_signal_ctrl pedx_signal_ctrl_chk #(
  .WALK_START (WALK_START),
  .CNT_W      (CNT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .walk_req (walk_req),
  .veh_grn  (veh_grn),
  .veh_amb  (veh_amb),
  .veh_red  (veh_red),
  .ped_grn  (ped_grn),
  .ped_red  (ped_red),
  .walk_cnt (walk_cnt)
);

// File: tb/pedx_signal_ctrl_bench.sv
module pedx_signal_ctrl_bench;

  localparam int WS    = 2;
  localparam int IDLE  = 7;
  localparam int CW    = $clog2(WS + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          walk_req = 1'b0;
  logic          veh_grn, veh_amb, veh_red, ped_grn, ped_red;
  logic [CW-1:0] walk_cnt;
  logic [6:0]    seg_abcdefg;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // model state: 0 idle, 1 amber, 2 walk
  int m_ph  = 0;
  int m_cnt = 0;

  always #4 clk = ~clk;

  pedx_signal_ctrl #(.WALK_START(WS), .IDLE_DIGIT(IDLE)) u_pedx_signal_ctrl (
    .clk         (clk),
    .rst         (rst),
    .walk_req    (walk_req),
    .veh_grn     (veh_grn),
    .veh_amb     (veh_amb),
    .veh_red     (veh_red),
    .ped_grn     (ped_grn),
    .ped_red     (ped_red),
    .walk_cnt    (walk_cnt),
    .seg_abcdefg (seg_abcdefg)
  );

  always @(posedge clk or posedge rst) begin
    if (rst) begin
      m_ph  <= 0;
      m_cnt <= 0;
    end else begin
      case (m_ph)
        0: if (walk_req) m_ph <= 1;
        1: begin m_ph <= 2; m_cnt <= WS; end
        default: begin
          if (m_cnt == 0) m_ph <= 0;
          else            m_cnt <= m_cnt - 1;
        end
      endcase
    end
  end

  function automatic logic [6:0] ref_seg(input int d);
    case (d)
      0: return 7'h7E;  1: return 7'h30;  2: return 7'h6D;
      3: return 7'h79;  4: return 7'h33;  5: return 7'h5B;
      6: return 7'h5F;  7: return 7'h70;  8: return 7'h7F;
      9: return 7'h7B;  default: return 7'h00;
    endcase
  endfunction

  task automatic cmp(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all(input string rtag);
    string lt;
    string ct;
    lt = (rtag != "") ? rtag : (m_ph == 0) ? "R2" : (m_ph == 1) ? "R3" : "R4";
    ct = (rtag != "") ? rtag : (m_ph == 2) ? "R5" : "R9";
    cmp({lt, " lamps"}, {veh_grn, veh_amb, veh_red, ped_grn, ped_red},
        {m_ph == 0, m_ph == 1, m_ph == 2, m_ph == 2, m_ph != 2});
    cmp({lt, " R7 lamp exclusivity"}, $countones({veh_grn, veh_amb, veh_red}), 1);
    cmp({ct, " count"}, int'(walk_cnt), (m_ph == 2) ? m_cnt : 0);
    cmp((rtag != "") ? {rtag, " seg"} : "R8 seg", int'(seg_abcdefg),
        int'(ref_seg((m_ph == 2) ? m_cnt : IDLE)));
  endtask

  task automatic step(input logic b);
    @(negedge clk);
    compare_all("");
    walk_req = b;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] lfsr;
    lfsr = 8'hA5;
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst = 1'b0;
    // R2: long idle
    repeat (6) step(1'b0);
    // R3/R4/R5: single press
    step(1'b1);
    repeat (8) step(1'b0);
    // R6: presses during amber and walk are dropped
    step(1'b1);
    repeat (4) step(1'b1);   // covers amber + walk cycles
    repeat (6) step(1'b0);
    @(negedge clk);
    cmp("R6 back to green after dropped presses", veh_grn, 1);
    // held press: back-to-back cycles
    repeat (14) step(1'b1);
    repeat (6) step(1'b0);
    // R1: async reset during walk
    step(1'b1);
    step(1'b0);
    step(1'b0);
    #1 rst = 1'b1;
    #1;
    cmp("R1 async reset green", {veh_grn, ped_red, veh_red}, 3'b110);
    cmp("R1 async reset count", int'(walk_cnt), 0);
    cmp("R1 async reset seg", int'(seg_abcdefg), int'(ref_seg(IDLE)));
    @(negedge clk);
    compare_all("R1");
    rst = 1'b0;
    // pseudo-random presses
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0] & lfsr[3]);
    end
    step(1'b0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule